// File: doc/BRIEF.md
# Octal SPI Register-Write Target

This block is the peripheral end of an eight-lane, single-data-rate serial link. The host drives a free-running serial clock and an active-low select. While select is low, the block takes one byte per rising serial-clock edge. The first byte is a command: bit 0 set to 1 means write. The next two bytes form a 16-bit register address, high byte first. The last four bytes form a 32-bit word, first byte in the top bits. A well-formed write is therefore exactly seven frames long.

When select returns high, the block judges the transaction. Exactly seven frames with a write command produce one register write. The address and word cross into the system clock domain through a toggle handshake and appear on a valid/ready port. Back-pressure rules for that port:
- Once `wr_valid` rises, it stays high, and `wr_addr` and `wr_data` stay unchanged, until the first system clock edge at which `wr_ready` is high.
- Each accepted write is offered exactly once.
- While a write is still unaccepted, a newer write cannot be queued. It is dropped and counted as a fault.

Transactions with any other frame count are faults. This includes stray filler bytes that a faulty host inserts between address and data. A fault never reaches the write port. It sets a sticky flag and increments a saturating counter. Both outputs are in the serial clock domain and clear only on reset.

Top module: `octal_wr_target`

## Requirements
- R1: While `rst_n` is low and after its release, `wr_valid` is 0, `err_flag` is 0 and `err_count` is 0.
- R2: A byte is sampled from `dq_in` on each rising `sclk` edge while `cs_n` is low. If exactly 7 bytes arrive and byte 0 has bit 0 = 1, exactly one write is offered on the write port after `cs_n` rises.
- R3: The write address is byte 1 in bits 15:8 and byte 2 in bits 7:0.
- R4: The write word is big-endian: byte 3 in bits 31:24, byte 4 in bits 23:16, byte 5 in bits 15:8, byte 6 in bits 7:0.
- R5: `wr_valid` stays high, with `wr_addr` and `wr_data` stable, until a cycle with `wr_ready` high. It falls on the following cycle, and each write is offered once.
- R6: A transaction of 1 to 6 bytes or of more than 7 bytes (for example an inserted filler byte 0x0C after the address) produces no write. It sets `err_flag`, which stays set, and increments `err_count` by one.
- R7: A 7-byte transaction whose byte 0 has bit 0 = 0 is ignored: no write, and no change to `err_flag` or `err_count`.
- R8: A valid write that completes while an earlier write is still unaccepted is dropped and counted as a fault. The pending address and word are unchanged.
- R9: `err_count` saturates at 2^ERR_W-1.
- R10: Frame counting restarts at every transaction. A well-formed write directly after a malformed one is delivered with the correct address and word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset for both clock domains |
| sclk | input | 1 | Free-running serial clock from the host |
| cs_n | input | 1 | Active-low transaction select |
| dq_in | input | LANES | Serial data lanes, one byte per frame |
| sys_clk | input | 1 | System clock for the write port |
| wr_valid | output | 1 | Write offered |
| wr_ready | input | 1 | Write accepted when high with `wr_valid` |
| wr_addr | output | ADDR_W | Register address of the offered write |
| wr_data | output | DATA_FRAMES*LANES | Word of the offered write |
| err_flag | output | 1 | Sticky fault flag (serial clock domain) |
| err_count | output | ERR_W | Saturating fault counter (serial clock domain) |

## Verification
The bench keeps the default link geometry of 8 lanes, a 16-bit address and 4 data frames. It reduces ERR_W to 3, so the fault counter reaches its saturation value of 7 after a handful of malformed transactions. With a two-stage synchronizer and a system clock faster than the serial clock, the pending-write window is short. The bench therefore holds `wr_ready` low to stretch that window. This makes the overrun fault and the stability of the held address and word observable.

// File: rtl/oswt_pkg.sv
package oswt_pkg;

  typedef enum logic [1:0] {
    END_IDLE,
    END_WRITE,
    END_SKIP,
    END_FAULT
  } verdict_e;

  function automatic int frame_total(input int addr_w, input int lanes, input int data_frames);
    return 1 + addr_w / lanes + data_frames;
  endfunction

endpackage

// File: rtl/oswt_sync.sv
module oswt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/oswt_frame_rx.sv
module oswt_frame_rx
  import oswt_pkg::*;
#(
  parameter int LANES       = 8,
  parameter int ADDR_W      = 16,
  parameter int DATA_FRAMES = 4,
  parameter int CNT_W       = 4
) (
  input  logic                         sclk,
  input  logic                         rst_n,
  input  logic                         cs_n,
  input  logic [LANES-1:0]             dq_in,
  output logic                         txn_end,
  output logic [CNT_W-1:0]             frames,
  output logic                         is_write,
  output logic [ADDR_W-1:0]            addr,
  output logic [DATA_FRAMES*LANES-1:0] data
);

  localparam int ADDR_FRAMES = ADDR_W / LANES;
  localparam int FRAMES      = frame_total(ADDR_W, LANES, DATA_FRAMES);
  localparam int DATA_W      = DATA_FRAMES * LANES;
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(FRAMES + 1);

  logic [CNT_W-1:0] idx, idx_inc;
  logic             active;
  logic [LANES-1:0] slot_q [1:FRAMES-1];

  assign idx_inc = (idx == CNT_MAX) ? idx : idx + 1'b1;

  // Frame index, cleared asynchronously whenever select is high.
  always_ff @(posedge sclk or posedge cs_n or negedge rst_n) begin
    if (!rst_n)    idx <= '0;
    else if (cs_n) idx <= '0;
    else           idx <= idx_inc;
  end

  always_ff @(posedge sclk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      frames <= '0;
    end else if (!cs_n) begin
      active <= 1'b1;
      frames <= idx_inc;
    end else begin
      active <= 1'b0;
    end
  end

  assign txn_end = cs_n & active;

  always_ff @(posedge sclk) begin
    if (!cs_n) begin
      if (idx == '0) is_write <= dq_in[0];
      for (int k = 1; k < FRAMES; k++) begin
        if (idx == CNT_W'(k)) slot_q[k] <= dq_in;
      end
    end
  end

  for (genvar a = 0; a < ADDR_FRAMES; a++) begin : g_addr
    assign addr[ADDR_W-1-a*LANES -: LANES] = slot_q[1+a];
  end

  for (genvar d = 0; d < DATA_FRAMES; d++) begin : g_data
    assign data[DATA_W-1-d*LANES -: LANES] = slot_q[1+ADDR_FRAMES+d];
  end

  AST_IDX_CLEARED: assert property (@(posedge sclk) disable iff (!rst_n)
    cs_n |-> idx == '0); // R10

  AST_END_AFTER_FRAME: assert property (@(posedge sclk) disable iff (!rst_n)
    txn_end |-> frames != '0); // R6

endmodule

// File: rtl/oswt_commit.sv
module oswt_commit
  import oswt_pkg::*;
#(
  parameter int CNT_W  = 4,
  parameter int FRAMES = 7,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int ERR_W  = 8
) (
  input  logic              sclk,
  input  logic              rst_n,
  input  logic              txn_end,
  input  logic [CNT_W-1:0]  frames,
  input  logic              is_write,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [DATA_W-1:0] data_in,
  input  logic              ack_seen,
  output logic              req_tgl,
  output logic [ADDR_W-1:0] hold_addr,
  output logic [DATA_W-1:0] hold_data,
  output logic              err_flag,
  output logic [ERR_W-1:0]  err_count
);

  verdict_e verdict;
  logic     busy;

  assign busy = req_tgl ^ ack_seen;

  always_comb begin
    verdict = END_IDLE;
    if (txn_end) begin
      if (frames != CNT_W'(FRAMES)) verdict = END_FAULT;
      else if (!is_write)           verdict = END_SKIP;
      else if (busy)                verdict = END_FAULT;
      else                          verdict = END_WRITE;
    end
  end

  always_ff @(posedge sclk or negedge rst_n) begin
    if (!rst_n) begin
      req_tgl   <= 1'b0;
      err_flag  <= 1'b0;
      err_count <= '0;
    end else begin
      if (verdict == END_WRITE) req_tgl <= ~req_tgl;
      if (verdict == END_FAULT) begin
        err_flag <= 1'b1;
        if (err_count != '1) err_count <= err_count + 1'b1;
      end
    end
  end

  always_ff @(posedge sclk or negedge rst_n) begin
    if (!rst_n) begin
      hold_addr <= '0;
      hold_data <= '0;
    end else if (verdict == END_WRITE) begin
      hold_addr <= addr_in;
      hold_data <= data_in;
    end
  end

  AST_HOLD_STABLE: assert property (@(posedge sclk) disable iff (!rst_n)
    (req_tgl != ack_seen) |=> $stable(hold_addr) && $stable(hold_data)); // R8

  AST_ERR_STICKY: assert property (@(posedge sclk) disable iff (!rst_n)
    err_flag |=> err_flag); // R6

  AST_ERR_ONLY_AT_END: assert property (@(posedge sclk) disable iff (!rst_n)
    !txn_end |=> $stable(err_count) && $stable(req_tgl)); // R2

endmodule

// File: rtl/oswt_sys_port.sv
module oswt_sys_port #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              sys_clk,
  input  logic              rst_n,
  input  logic              req_sync,
  input  logic [ADDR_W-1:0] hold_addr,
  input  logic [DATA_W-1:0] hold_data,
  input  logic              wr_ready,
  output logic              wr_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              ack_tgl
);

  logic req_last;

  always_ff @(posedge sys_clk or negedge rst_n) begin
    if (!rst_n) begin
      req_last <= 1'b0;
      wr_valid <= 1'b0;
      ack_tgl  <= 1'b0;
    end else begin
      req_last <= req_sync;
      if (req_sync != req_last) begin
        wr_valid <= 1'b1;
      end else if (wr_valid && wr_ready) begin
        wr_valid <= 1'b0;
        ack_tgl  <= ~ack_tgl;
      end
    end
  end

  assign wr_addr = hold_addr;
  assign wr_data = hold_data;

  AST_VALID_HOLD: assert property (@(posedge sys_clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data)); // R5

  AST_VALID_DROP: assert property (@(posedge sys_clk) disable iff (!rst_n)
    wr_valid && wr_ready |=> !wr_valid); // R5

endmodule

// File: rtl/octal_wr_target.sv
module octal_wr_target
  import oswt_pkg::*;
#(
  parameter int LANES       = 8,
  parameter int ADDR_W      = 16,
  parameter int DATA_FRAMES = 4,
  parameter int ERR_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                         rst_n,
  input  logic                         sclk,
  input  logic                         cs_n,
  input  logic [LANES-1:0]             dq_in,
  input  logic                         sys_clk,
  output logic                         wr_valid,
  input  logic                         wr_ready,
  output logic [ADDR_W-1:0]            wr_addr,
  output logic [DATA_FRAMES*LANES-1:0] wr_data,
  output logic                         err_flag,
  output logic [ERR_W-1:0]             err_count
);

  localparam int FRAMES = frame_total(ADDR_W, LANES, DATA_FRAMES);
  localparam int CNT_W  = $clog2(FRAMES + 2);
  localparam int DATA_W = DATA_FRAMES * LANES;

  logic              txn_end, is_write;
  logic [CNT_W-1:0]  frames;
  logic [ADDR_W-1:0] rx_addr, hold_addr;
  logic [DATA_W-1:0] rx_data, hold_data;
  logic              req_tgl, req_sync, ack_tgl, ack_seen;

  oswt_frame_rx #(
    .LANES(LANES), .ADDR_W(ADDR_W), .DATA_FRAMES(DATA_FRAMES), .CNT_W(CNT_W)
  ) u_rx (
    .sclk(sclk), .rst_n(rst_n), .cs_n(cs_n), .dq_in(dq_in),
    .txn_end(txn_end), .frames(frames), .is_write(is_write),
    .addr(rx_addr), .data(rx_data)
  );

  oswt_commit #(
    .CNT_W(CNT_W), .FRAMES(FRAMES), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ERR_W(ERR_W)
  ) u_commit (
    .sclk(sclk), .rst_n(rst_n), .txn_end(txn_end), .frames(frames),
    .is_write(is_write), .addr_in(rx_addr), .data_in(rx_data),
    .ack_seen(ack_seen), .req_tgl(req_tgl), .hold_addr(hold_addr),
    .hold_data(hold_data), .err_flag(err_flag), .err_count(err_count)
  );

  oswt_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk(sys_clk), .rst_n(rst_n), .d(req_tgl), .q(req_sync)
  );

  oswt_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk(sclk), .rst_n(rst_n), .d(ack_tgl), .q(ack_seen)
  );

  oswt_sys_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_port (
    .sys_clk(sys_clk), .rst_n(rst_n), .req_sync(req_sync),
    .hold_addr(hold_addr), .hold_data(hold_data), .wr_ready(wr_ready),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data), .ack_tgl(ack_tgl)
  );

endmodule

// File: tb/sim_octal_wr_target.sv
module sim_octal_wr_target;

  logic        rst_n = 1'b0;
  logic        sclk = 1'b0;
  logic        sys_clk = 1'b0;
  logic        cs_n = 1'b1;
  logic [7:0]  dq_in = '0;
  logic        wr_ready = 1'b1;
  logic        wr_valid, err_flag;
  logic [15:0] wr_addr;
  logic [31:0] wr_data;
  logic [2:0]  err_count;

  int n_chk = 0;
  int n_fail = 0;
  int hs_n = 0;
  logic [15:0] hs_addr = '0;
  logic [31:0] hs_data = '0;

  always #2 sys_clk = ~sys_clk;
  always #5 sclk = ~sclk;

  octal_wr_target #(.ERR_W(3)) u0 (
    .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .dq_in(dq_in), .sys_clk(sys_clk),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .err_flag(err_flag), .err_count(err_count)
  );

  always @(negedge sys_clk) begin
    if (rst_n && wr_valid && wr_ready) begin
      hs_n++;
      hs_addr = wr_addr;
      hs_data = wr_data;
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [127:0] mk7(input logic [7:0] c, input logic [15:0] a, input logic [31:0] d);
    logic [127:0] f;
    f = '0;
    f[7:0]   = c;
    f[15:8]  = a[15:8];
    f[23:16] = a[7:0];
    f[31:24] = d[31:24];
    f[39:32] = d[23:16];
    f[47:40] = d[15:8];
    f[55:48] = d[7:0];
    return f;
  endfunction

  task automatic send(input logic [127:0] fr, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge sclk);
      cs_n = 1'b0;
      dq_in = fr[i*8 +: 8];
    end
    @(negedge sclk);
    cs_n = 1'b1;
    dq_in = '0;
  endtask

  task automatic settle();
    repeat (12) @(negedge sclk);
  endtask

  task automatic t_reset();
    chk("R1 wr_valid", 64'(wr_valid), 64'd0);
    chk("R1 err_flag", 64'(err_flag), 64'd0);
    chk("R1 err_count", 64'(err_count), 64'd0);
  endtask

  task automatic t_write(input string tag, input logic [7:0] c, input logic [15:0] a,
                         input logic [31:0] d, input logic [2:0] exp_err);
    int h0;
    h0 = hs_n;
    send(mk7(c, a, d), 7);
    settle();
    chk({tag, " R2 one write"}, 64'(hs_n - h0), 64'd1);
    chk({tag, " R3 address"}, 64'(hs_addr), 64'(a));
    chk({tag, " R4 word"}, 64'(hs_data), 64'(d));
    chk({tag, " R6 no fault"}, 64'(err_count), 64'(exp_err));
  endtask

  task automatic t_read_cmd();
    int h0;
    h0 = hs_n;
    send(mk7(8'h02, 16'h1234, 32'hCAFEF00D), 7);
    settle();
    chk("R7 no write", 64'(hs_n - h0), 64'd0);
    chk("R7 err_flag unchanged", 64'(err_flag), 64'd0);
    chk("R7 err_count unchanged", 64'(err_count), 64'd0);
  endtask

  task automatic t_bad(input string tag, input logic [127:0] fr, input int n, input logic [2:0] exp_err);
    int h0;
    h0 = hs_n;
    send(fr, n);
    settle();
    chk({tag, " R6 no write"}, 64'(hs_n - h0), 64'd0);
    chk({tag, " R6 err_flag"}, 64'(err_flag), 64'd1);
    chk({tag, " R6/R9 err_count"}, 64'(err_count), 64'(exp_err));
  endtask

  task automatic t_backpressure();
    int h0;
    logic [15:0] a0;
    logic [31:0] d0;
    h0 = hs_n;
    @(posedge sys_clk); #1 wr_ready = 1'b0;
    send(mk7(8'h01, 16'h0ACE, 32'h0BADC0DE), 7);
    settle();
    @(negedge sys_clk);
    chk("R5 valid held", 64'(wr_valid), 64'd1);
    chk("R5 address offered", 64'(wr_addr), 64'h0ACE);
    a0 = wr_addr;
    d0 = wr_data;
    repeat (5) @(negedge sys_clk);
    chk("R5 still valid", 64'(wr_valid), 64'd1);
    chk("R5 word stable", 64'(wr_data), 64'(d0));
    send(mk7(8'h01, 16'h5555, 32'h99999999), 7);
    settle();
    @(negedge sys_clk);
    chk("R8 overrun counted", 64'(err_count), 64'd4);
    chk("R8 address unchanged", 64'(wr_addr), 64'(a0));
    chk("R8 word unchanged", 64'(wr_data), 64'(d0));
    @(posedge sys_clk); #1 wr_ready = 1'b1;
    settle();
    settle();
    chk("R5 single transfer", 64'(hs_n - h0), 64'd1);
    chk("R5 accepted word", 64'(hs_data), 64'h0BADC0DE);
    chk("R5 valid dropped", 64'(wr_valid), 64'd0);
  endtask

  task automatic t_saturate();
    t_bad("R9 short 1", 128'h01, 1, 3'd5);
    t_bad("R9 short 3", 128'h080001, 3, 3'd6);
    t_bad("R9 short 2", 128'h0001, 2, 3'd7);
    t_bad("R9 saturated", 128'h0001, 2, 3'd7);
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL R2 watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [127:0] fr;
    repeat (3) @(negedge sys_clk);
    t_reset();
    repeat (3) @(negedge sys_clk);
    rst_n = 1'b1;
    repeat (4) @(negedge sclk);
    t_reset();
    t_write("basic", 8'h01, 16'h0008, 32'h12345678, 3'd0);
    t_write("pattern", 8'h81, 16'hA5C3, 32'hDEADBEEF, 3'd0);
    t_read_cmd();
    // Filler 0x0C after the address: 8 frames.
    fr = '0;
    fr[7:0] = 8'h01; fr[15:8] = 8'h00; fr[23:16] = 8'h08; fr[31:24] = 8'h0C;
    fr[39:32] = 8'hFF; fr[47:40] = 8'hFF; fr[55:48] = 8'hFF; fr[63:56] = 8'hFF;
    t_bad("filler", fr, 8, 3'd1);
    t_write("R10 recover", 8'h01, 16'h0008, 32'hFFFFFFFF, 3'd1);
    t_bad("short", mk7(8'h01, 16'h0040, 32'h11223344), 5, 3'd2);
    // Six fillers: 13 frames.
    fr = '0;
    fr[7:0] = 8'h01; fr[15:8] = 8'h00; fr[23:16] = 8'h10;
    for (int i = 3; i < 9; i++) fr[i*8 +: 8] = 8'h0C;
    for (int i = 9; i < 13; i++) fr[i*8 +: 8] = 8'h5A;
    t_bad("long", fr, 13, 3'd3);
    t_backpressure();
    t_saturate();
    t_write("R10 after faults", 8'h01, 16'hFFFF, 32'h00000001, 3'd7);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule